// File: doc/BRIEF.md
# NRZ to Manchester Serial Encoder

This block turns a serial NRZ data stream into Manchester code. It runs from a clock at twice the bit rate. Each data bit is held on the input for two consecutive clocks, and the block emits one half-bit symbol on each of those clocks. A data 0 comes out as low then high, and a data 1 as high then low.

A parameter picks between two state machines. The Mealy form has three states and drives the first half of each bit straight from the input, so the output is aligned with the ideal waveform but can glitch when the input moves between edges. The Moore form has four states, drives the output from a flop, and arrives one clock later than the ideal waveform. Both forms treat the input during the second clock of a bit as irrelevant. The first bit is taken to begin on the first clock after reset is released.

Top module: `nrz_to_manchester`

## Requirements
- R1: While rst_ni is low at a clock edge, the machine returns to its idle first-half state. The Moore output reads 0 after such an edge. The Mealy output then equals nrz_i.
- R2: Mealy form (USE_MOORE=0): in the first clock of a bit man_o equals nrz_i, and in the second clock it is the complement of that first-half value. So 0 gives 0,1 and 1 gives 1,0, with no delay against the input.
- R3: Mealy form: during the first clock of a bit, man_o follows a change of nrz_i between edges without waiting for a clock edge.
- R4: Mealy form: nrz_i during the second clock of a bit has no effect on man_o. The next bit is encoded from the idle state whatever that input was.
- R5: Moore form (USE_MOORE=1): man_o in clock n equals the ideal Manchester half-bit of clock n-1. The ideal half-bit is defined as in R2, and man_o is 0 in the first clock after reset.
- R6: Moore form: man_o changes only at clock edges, so a change of nrz_i between edges leaves it steady.
- R7: Moore form: nrz_i during the second clock of a bit has no effect on man_o. That half-bit is the complement of the one before it.
- R8: The bit sequence 0,1,1,1,0,0,1,0 gives the half-bit sequence 01 10 10 10 01 01 10 01. The Mealy form produces it aligned with the input, and the Moore form produces it one clock later.
- R9: A reset asserted in the middle of a bit abandons that bit. After release, encoding restarts with a first half on the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock at twice the bit rate |
| rst_ni | input | 1 | Synchronous reset, active low |
| nrz_i | input | 1 | NRZ data, held for two clocks per bit |
| man_o | output | 1 | Manchester half-bit output |

## Verification
The encoder is driven with the fixed eight-bit reference sequence, with long runs of zeros and of ones, with strict alternation, and with a pseudo-random stream. Runs of equal bits show that each bit restarts from the idle state rather than continuing the previous one. Alternation shows that the symbols change on every bit boundary. Separate patterns flip the input in the middle of a first-half clock, which separates the combinational Mealy path from the registered Moore path. Other patterns drive an inverted value during second-half clocks, which shows that both forms ignore that input.

// File: rtl/manch_pkg.sv
// Shared state encodings for the NRZ to Manchester encoder.
// Assumes a clock at twice the bit rate; states are named by half-bit phase.
package manch_pkg;

    // Mealy states: awaiting first half, or finishing a bit with high / low.
    typedef enum logic [1:0] {
        ME_FIRST   = 2'b00,
        ME_SEC_HI  = 2'b01,
        ME_SEC_LO  = 2'b10
    } mealy_st_e;

    // Moore states; bit 1 of the code is the registered output level.
    typedef enum logic [1:0] {
        MO_WAIT_LO = 2'b00,
        MO_HOLD_LO = 2'b01,
        MO_WAIT_HI = 2'b11,
        MO_HOLD_HI = 2'b10
    } moore_st_e;

    localparam int unsigned OUT_BIT = 1;

endpackage

// File: rtl/manch_mealy_enc.sv
// Mealy Manchester encoder: three states, first half driven straight from
// the input, second half decoded from state.
// Assumes the input is held for two clocks per bit and the first bit starts
// on the clock after reset release.
module manch_mealy_enc
    import manch_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic x_i,
    output logic z_o
);

    mealy_st_e st_q, st_d;

    // State register with synchronous active-low reset.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= ME_FIRST;
        else         st_q <= st_d;
    end

    // Next state and output; the second half ignores the input.
    always_comb begin
        st_d = ME_FIRST;
        z_o  = 1'b0;
        case (st_q)
            ME_FIRST: begin
                z_o  = x_i;
                st_d = x_i ? ME_SEC_LO : ME_SEC_HI;
            end
            ME_SEC_HI: begin
                z_o  = 1'b1;
                st_d = ME_FIRST;
            end
            ME_SEC_LO: begin
                z_o  = 1'b0;
                st_d = ME_FIRST;
            end
            default: begin
                z_o  = 1'b0;
                st_d = ME_FIRST;
            end
        endcase
    end

    // Phase alternates: a first half is always followed by a second half.
    p_phase_leave_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q == ME_FIRST) |=> (st_q != ME_FIRST));
    // A second half always hands back to the first-half state.
    p_phase_return_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q != ME_FIRST) |=> (st_q == ME_FIRST));
    // The second half-bit is the complement of the first.
    p_second_inverts_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q == ME_FIRST) |=> (z_o != $past(z_o)));

endmodule

// File: rtl/manch_moore_enc.sv
// Moore Manchester encoder: four states, output taken from a state flop so
// it only moves at clock edges; lags the ideal waveform by one clock.
// Assumes the input is held for two clocks per bit.
module manch_moore_enc
    import manch_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic x_i,
    output logic z_o
);

    moore_st_e st_q, st_d;

    // State register with synchronous active-low reset.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= MO_WAIT_LO;
        else         st_q <= st_d;
    end

    // Next state; hold states ignore the input and flip the level.
    always_comb begin
        case (st_q)
            MO_WAIT_LO: st_d = x_i ? MO_HOLD_HI : MO_HOLD_LO;
            MO_WAIT_HI: st_d = x_i ? MO_HOLD_HI : MO_HOLD_LO;
            MO_HOLD_LO: st_d = MO_WAIT_HI;
            MO_HOLD_HI: st_d = MO_WAIT_LO;
            default:    st_d = MO_WAIT_LO;
        endcase
    end

    // Output is the level bit of the state code.
    assign z_o = st_q[OUT_BIT];

    // Reset forces a low output on the following cycle.
    p_reset_low_r1: assert property (@(posedge clk_i)
        !rst_ni |=> !z_o);
    // A first-half input shows up on the output one clock later.
    p_capture_lag_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((st_q == MO_WAIT_LO) || (st_q == MO_WAIT_HI)) |=> (z_o == $past(x_i)));
    // The second half flips the level regardless of the input.
    p_hold_flips_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((st_q == MO_HOLD_LO) || (st_q == MO_HOLD_HI)) |=> (z_o != $past(z_o)));

endmodule

// File: rtl/nrz_to_manchester.sv
// NRZ to Manchester encoder top; USE_MOORE selects the registered four-state
// form (1) or the three-state form with a combinational first half (0).
// Assumes a clock at twice the bit rate and two clocks per input bit.
module nrz_to_manchester #(
    parameter bit USE_MOORE = 1'b1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic nrz_i,
    output logic man_o
);

    // Pick the encoder variant.
    generate
        if (USE_MOORE) begin : g_moore
            manch_moore_enc u_enc (
                .clk_i  (clk_i),
                .rst_ni (rst_ni),
                .x_i    (nrz_i),
                .z_o    (man_o)
            );
        end else begin : g_mealy
            manch_mealy_enc u_enc (
                .clk_i  (clk_i),
                .rst_ni (rst_ni),
                .x_i    (nrz_i),
                .z_o    (man_o)
            );
        end
    endgenerate

endmodule

// File: tb/nrz_to_manchester_bench.sv
// Directed bench: drives both variants with the same stream; Mealy output is
// compared with the ideal half-bit, Moore output with the previous one.
module nrz_to_manchester_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic nrz = 1'b0;
    logic z_moore, z_mealy;
    int   n_chk = 0;
    int   n_bad = 0;
    logic prev_ideal = 1'b0;
    bit   finished = 1'b0;

    always #5 clk = ~clk;

    nrz_to_manchester #(.USE_MOORE(1'b1)) u_nrz_to_manchester (
        .clk_i(clk), .rst_ni(rst_n), .nrz_i(nrz), .man_o(z_moore));

    nrz_to_manchester #(.USE_MOORE(1'b0)) u_nrz_to_manchester_mly (
        .clk_i(clk), .rst_ni(rst_n), .nrz_i(nrz), .man_o(z_mealy));

    task automatic check(input logic act, input logic exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // One half-bit clock: drive input, check both outputs before the edge.
    task automatic half(input logic x, input logic ideal, input string tag);
        @(negedge clk);
        rst_n = 1'b1;
        nrz = x;
        #3;
        check(z_mealy, ideal, {tag, " mealy"});
        check(z_moore, prev_ideal, {tag, " moore"});
        prev_ideal = ideal;
    endtask

    // One bit; bad_sec drives the inverted value in the second half.
    task automatic send_bit(input logic b, input logic bad_sec, input string tag);
        half(b, b, tag);
        half(bad_sec ? ~b : b, ~b, tag);
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0;
        nrz = 1'b1;
        repeat (2) @(negedge clk);
        #3;
        check(z_moore, 1'b0, "R1 moore low in reset");
        check(z_mealy, 1'b1, "R1 mealy follows input in reset");
        nrz = 1'b0;
        #1;
        check(z_mealy, 1'b0, "R1 mealy follows input in reset");
        prev_ideal = 1'b0;
    endtask

    task automatic t_reference();
        logic [7:0] seq = 8'b0111_0010;
        t_reset();
        for (int i = 7; i >= 0; i--) send_bit(seq[i], 1'b0, "R8 reference");
        half(1'b0, 1'b0, "R8 reference tail");
    endtask

    task automatic t_runs();
        t_reset();
        for (int i = 0; i < 6; i++) send_bit(1'b0, 1'b0, "R2 R5 zeros");
        for (int i = 0; i < 6; i++) send_bit(1'b1, 1'b0, "R2 R5 ones");
        for (int i = 0; i < 8; i++) send_bit(i[0], 1'b0, "R2 R5 alternate");
    endtask

    task automatic t_random();
        logic [15:0] lfsr = 16'hACE1;
        t_reset();
        for (int i = 0; i < 300; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            send_bit(lfsr[0], 1'b0, "R2 R5 random");
        end
    endtask

    task automatic t_glitch();
        t_reset();
        send_bit(1'b0, 1'b0, "R3 lead");
        @(negedge clk);
        nrz = 1'b0;
        #1;
        check(z_mealy, 1'b0, "R3 mealy before change");
        check(z_moore, prev_ideal, "R6 moore before change");
        nrz = 1'b1;
        #1;
        check(z_mealy, 1'b1, "R3 mealy follows mid-cycle change");
        check(z_moore, prev_ideal, "R6 moore steady on mid-cycle change");
        prev_ideal = 1'b1;
        half(1'b1, 1'b0, "R3 R6 second half");
        send_bit(1'b1, 1'b0, "R3 R6 follow");
    endtask

    task automatic t_dont_care();
        t_reset();
        for (int i = 0; i < 6; i++) send_bit(i[1], 1'b1, "R4 R7 flipped second half");
        send_bit(1'b1, 1'b0, "R4 R7 after");
        send_bit(1'b1, 1'b0, "R4 R7 after");
    endtask

    task automatic t_midreset();
        t_reset();
        send_bit(1'b0, 1'b0, "R9 lead");
        half(1'b1, 1'b1, "R9 partial");
        @(negedge clk);
        rst_n = 1'b0;
        nrz = 1'b1;
        @(negedge clk);
        #3;
        check(z_moore, 1'b0, "R9 moore cleared");
        check(z_mealy, 1'b1, "R9 mealy back in first-half state");
        prev_ideal = 1'b0;
        send_bit(1'b1, 1'b0, "R9 restart");
        send_bit(1'b0, 1'b0, "R9 restart");
    endtask

    initial begin
        t_reset();
        t_reference();
        t_runs();
        t_glitch();
        t_dont_care();
        t_midreset();
        t_random();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule